// File: doc/BRIEF.md
# Multi-Phase Voltage Sag Detector

The detector watches three phase-voltage sample streams and decides, one half-line cycle at a time, whether each phase has dipped. A per-phase boundary strobe closes each half cycle. The largest absolute sample seen in that half cycle, including the sample present with the strobe, is compared against a programmable magnitude level. A half cycle whose peak lies strictly below the level counts as a low half cycle. When a phase collects the programmed number of consecutive low half cycles, the detector raises a sticky sag flag. It also marks that phase in a three-bit phase field and pulls an active-low interrupt.

Software services the event with one write to the status word. When that write has bit 16 set, the flag and every phase bit are cleared in a single step. A per-phase tracker fires only once per dip. It re-arms only after the phase shows a half cycle that is not low, so a long sag raises exactly one event.

Each tracker is a three-state machine:
- TRK_ARMED: no low half cycles counted.
- TRK_COUNTING: some low half cycles counted.
- TRK_LATCHED: the event has fired and the tracker waits for recovery.

The tracker moves as follows:
- ARMED→COUNTING on a low half cycle that does not yet reach the count.
- ARMED or COUNTING→LATCHED on the low half cycle that reaches the count. This transition emits a one-cycle fire pulse.
- COUNTING→ARMED or LATCHED→ARMED on any half cycle that is not low.
- COUNTING→COUNTING and LATCHED→LATCHED on further low half cycles.

The status register is a two-state machine:
- ST_QUIET→ST_FLAGGED on any fire pulse.
- ST_FLAGGED→ST_QUIET on a clearing write with no fire pulse in the same cycle.
- ST_FLAGGED→ST_FLAGGED otherwise.

Top module: `sag_watch`

## Requirements
- R1: A half cycle is low when the largest absolute value of the phase's samples is strictly below `sag_level`. This covers every sample since the previous strobe up to and including the sample on the strobe cycle, and negative samples count by magnitude. A peak equal to or above the level makes the half cycle not low.
- R2: With a count setting N ≥ 1, the sag flag is set by the strobe that closes the Nth consecutive low half cycle. If that strobe is sampled at clock edge E, the flag is visible after edge E+1, and not earlier.
- R3: Any half cycle that is not low resets that phase's consecutive count to zero.
- R4: A count setting of 0 behaves exactly like a setting of 1.
- R5: The flag and the phase bits are sticky: bit 0 of `sag_phase` is phase A, bit 1 is phase B, bit 2 is phase C. Events on further phases add their bits.
- R6: A write with `st_wr_data[16]` = 1 clears the flag and all three phase bits on the write edge. A write with bit 16 = 0 changes nothing.
- R7: `sag_irq_n` is 0 exactly while the sag flag is 1.
- R8: When a new sag fires in the same cycle as a clearing write, the flag stays 1 and the phase field holds only the newly fired phase bits.
- R9: A phase fires once per dip. After firing, further low half cycles do not fire again until that phase has had a half cycle that is not low.
- R10: After reset the flag is 0, the phase field is 0 and `sag_irq_n` is 1.
- R11: Phases are tracked independently. Simultaneous qualifying phases set their bits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_bus | input | 72 | Three two's-complement samples; phase A in bits 23:0, B in 47:24, C in 71:48 |
| hc_end | input | 3 | Half-cycle boundary strobe per phase (bit 0 = A) |
| sag_level | input | 24 | Magnitude threshold |
| sag_cycles | input | 8 | Consecutive low half cycles required (0 acts as 1) |
| st_wr_en | input | 1 | Status-word write strobe |
| st_wr_data | input | 32 | Status-word write data; bit 16 = 1 clears |
| sag_flag | output | 1 | Sticky sag flag |
| sag_phase | output | 3 | Sticky per-phase sag bits |
| sag_irq_n | output | 1 | Active-low interrupt |

## Verification
A strobe sampled at edge E becomes a tracker fire pulse after E and a status change after E+1. A clearing or ignored write is sampled at its own edge and its effect is visible right after that edge. The driver task pushes each expected status only at the falling edge after the edge where the result is due. The monitor compares it one nanosecond later, well before the next rising edge. For the same-cycle case the driver places the write on edge E+1, so that write and fire meet at the status register.

// File: rtl/sag_watch_pkg.sv
package sag_watch_pkg;

    typedef enum logic [1:0] {
        TRK_ARMED    = 2'd0,
        TRK_COUNTING = 2'd1,
        TRK_LATCHED  = 2'd2
    } trk_state_e;

    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_FLAGGED = 1'b1
    } stat_state_e;

endpackage

// File: rtl/sag_phase_track.sv
module sag_phase_track
    import sag_watch_pkg::*;
#(
    parameter int SW = 24,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample,
    input  logic          hc_end,
    input  logic [SW-1:0] level,
    input  logic [CW-1:0] cycles,
    output logic          fire
);

    trk_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d, cnt_inc, need;
    logic [SW-1:0] peak_q, mag, hc_peak;
    logic          is_low, fire_d;

    // magnitude of a two's-complement sample; the most negative value maps to 2^(SW-1)
    always_comb begin
        mag     = sample[SW-1] ? (~sample + 1'b1) : sample;
        hc_peak = (mag > peak_q) ? mag : peak_q;
        is_low  = (hc_peak < level);
        need    = (cycles == '0) ? CW'(1) : cycles;   // R4: zero acts as one
        cnt_inc = cnt_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_ARMED;
            cnt_q   <= '0;
            peak_q  <= '0;
            fire    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            peak_q  <= hc_end ? '0 : hc_peak;
            fire    <= fire_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire_d  = 1'b0;
        if (hc_end) begin
            unique case (state_q)
                TRK_ARMED, TRK_COUNTING: begin
                    if (!is_low) begin
                        state_d = TRK_ARMED;       // R3
                        cnt_d   = '0;
                    end else if (cnt_inc >= need) begin
                        state_d = TRK_LATCHED;     // R2
                        cnt_d   = '0;
                        fire_d  = 1'b1;
                    end else begin
                        state_d = TRK_COUNTING;
                        cnt_d   = cnt_inc;
                    end
                end
                TRK_LATCHED: begin
                    if (!is_low) begin
                        state_d = TRK_ARMED;       // R9 re-arm
                    end
                end
                default: begin
                    state_d = TRK_ARMED;
                    cnt_d   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sag_status_reg.sv
module sag_status_reg
    import sag_watch_pkg::*;
#(
    parameter int NPH     = 3,
    parameter int STW     = 32,
    parameter int CLR_BIT = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] fire,
    input  logic           wr_en,
    input  logic [STW-1:0] wr_data,
    output logic           flag,
    output logic [NPH-1:0] phase,
    output logic           irq_n
);

    stat_state_e    state_q, state_d;
    logic [NPH-1:0] phase_q, phase_d;
    logic           clr, any_fire;

    always_comb begin
        clr      = wr_en && wr_data[CLR_BIT];   // R6
        any_fire = |fire;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        phase_d = (clr ? '0 : phase_q) | fire;  // R8: new bits survive a clear
        unique case (state_q)
            ST_QUIET:   if (any_fire) state_d = ST_FLAGGED;
            ST_FLAGGED: if (clr && !any_fire) state_d = ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
        flag  = (state_q == ST_FLAGGED);
        phase = phase_q;
        irq_n = (state_q != ST_FLAGGED);        // R7
    end

endmodule

// File: rtl/sag_watch.sv
module sag_watch
    import sag_watch_pkg::*;
#(
    parameter int NPH     = 3,
    parameter int SW      = 24,
    parameter int CW      = 8,
    parameter int STW     = 32,
    parameter int CLR_BIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPH*SW-1:0]  smp_bus,
    input  logic [NPH-1:0]     hc_end,
    input  logic [SW-1:0]      sag_level,
    input  logic [CW-1:0]      sag_cycles,
    input  logic               st_wr_en,
    input  logic [STW-1:0]     st_wr_data,
    output logic               sag_flag,
    output logic [NPH-1:0]     sag_phase,
    output logic               sag_irq_n
);

    logic [NPH-1:0] fire_vec;

    // R11: one independent tracker per phase
    for (genvar g = 0; g < NPH; g++) begin : g_trk
        sag_phase_track #(
            .SW (SW),
            .CW (CW)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (smp_bus[g*SW +: SW]),
            .hc_end (hc_end[g]),
            .level  (sag_level),
            .cycles (sag_cycles),
            .fire   (fire_vec[g])
        );
    end

    sag_status_reg #(
        .NPH     (NPH),
        .STW     (STW),
        .CLR_BIT (CLR_BIT)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire_vec),
        .wr_en   (st_wr_en),
        .wr_data (st_wr_data),
        .flag    (sag_flag),
        .phase   (sag_phase),
        .irq_n   (sag_irq_n)
    );

endmodule

// File: rtl/sag_watch_chk.sv
module sag_watch_chk #(
    parameter int NPH     = 3,
    parameter int STW     = 32,
    parameter int CLR_BIT = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NPH-1:0] hc_end,
    input logic [NPH-1:0] fire,
    input logic           wr_en,
    input logic [STW-1:0] wr_data,
    input logic           flag,
    input logic [NPH-1:0] phase
);

    // R2: a tracker fires only right after its own strobe
    a_r2_fire_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (fire & ~$past(hc_end)) == '0);

    // R8: a fire pulse always leaves the flag and its phase bits set
    a_r8_fire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> (flag && ((phase & $past(fire)) == $past(fire))));

    // R6: a clearing write with no new event empties the status
    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CLR_BIT] && (fire == '0)) |=> (!flag && (phase == '0)));

    // R5: without a clearing write, flag and phase bits hold
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && wr_data[CLR_BIT]))
            |=> (flag && ((phase & $past(phase)) == $past(phase))));

    // R5: a raised flag always names at least one phase
    a_r5_flag_has_phase: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (phase != '0));

endmodule

bind sag_watch sag_watch_chk #(
    .NPH     (NPH),
    .STW     (STW),
    .CLR_BIT (CLR_BIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hc_end  (hc_end),
    .fire    (fire_vec),
    .wr_en   (st_wr_en),
    .wr_data (st_wr_data),
    .flag    (sag_flag),
    .phase   (sag_phase)
);

// File: tb/sag_watch_test.sv
module sag_watch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] smp_bus = '0;
    logic [2:0]  hc_end = '0;
    logic [23:0] sag_level = 24'd1000;
    logic [7:0]  sag_cycles = 8'd3;
    logic        st_wr_en = 1'b0;
    logic [31:0] st_wr_data = '0;
    logic        sag_flag;
    logic [2:0]  sag_phase;
    logic        sag_irq_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       flag;
        logic [2:0] ph;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    sag_watch uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_bus    (smp_bus),
        .hc_end     (hc_end),
        .sag_level  (sag_level),
        .sag_cycles (sag_cycles),
        .st_wr_en   (st_wr_en),
        .st_wr_data (st_wr_data),
        .sag_flag   (sag_flag),
        .sag_phase  (sag_phase),
        .sag_irq_n  (sag_irq_n)
    );

    // monitor: compare each expected item once the design has produced it
    initial begin : monitor
        exp_t e;
        forever begin
            wait (sb_q.size() > 0);
            #1;
            e = sb_q.pop_front();
            n_vec++;
            if (sag_flag !== e.flag || sag_phase !== e.ph || sag_irq_n !== ~e.flag) begin
                n_bad++;
                $display("FAIL %s: flag=%0b phase=%b irq_n=%0b expected flag=%0b phase=%b irq_n=%0b",
                         e.tag, sag_flag, sag_phase, sag_irq_n, e.flag, e.ph, ~e.flag);
            end
        end
    end

    task automatic expect_st(input logic f, input logic [2:0] p, input string tag);
        exp_t e;
        e.flag = f;
        e.ph   = p;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // one half cycle of four samples on every phase; peak at position pk,
    // strobe on the last sample; optional status write on the edge after
    task automatic run_hc(input logic [2:0] strb, input int amp, input bit neg,
                          input int pk, input bit wr_end, input logic [31:0] wd);
        for (int k = 0; k < 4; k++) begin
            logic [23:0] v;
            v = (k == pk) ? 24'(amp) : 24'(amp / 2);
            if (neg) v = -v;
            smp_bus = {v, v, v};
            hc_end  = (k == 3) ? strb : 3'b000;
            @(negedge clk);
        end
        hc_end  = '0;
        smp_bus = '0;
        if (wr_end) begin
            st_wr_en   = 1'b1;
            st_wr_data = wd;
        end
        @(negedge clk);
        st_wr_en   = 1'b0;
        st_wr_data = '0;
    endtask

    task automatic wr_status(input logic [31:0] wd);
        st_wr_en   = 1'b1;
        st_wr_data = wd;
        @(negedge clk);
        st_wr_en   = 1'b0;
        st_wr_data = '0;
    endtask

    localparam logic [31:0] CLR = 32'h0001_0000;

    initial begin : driver
        repeat (3) @(negedge clk);
        expect_st(1'b0, 3'b000, "R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        expect_st(1'b0, 3'b000, "R10 after release");

        // R2: phase A, three lows at count 3
        run_hc(3'b001, 500, 1'b0, 1, 1'b0, '0);
        expect_st(1'b0, 3'b000, "R2 first low");
        run_hc(3'b001, 500, 1'b0, 1, 1'b0, '0);
        expect_st(1'b0, 3'b000, "R2 second low");
        run_hc(3'b001, 500, 1'b1, 2, 1'b0, '0);
        expect_st(1'b1, 3'b001, "R2 third low sets A");
        run_hc(3'b001, 500, 1'b0, 1, 1'b0, '0);
        expect_st(1'b1, 3'b001, "R5 flag sticky");

        // R6: write without bit 16, then a clearing write
        wr_status(32'hFFFE_FFFF);
        expect_st(1'b1, 3'b001, "R6 write without bit16 ignored");
        wr_status(CLR);
        expect_st(1'b0, 3'b000, "R6 clear");

        // R9: still low, no new event
        run_hc(3'b001, 500, 1'b0, 1, 1'b0, '0);
        expect_st(1'b0, 3'b000, "R9 no refire while low");

        // R1: peak equal to level is not low, rearms
        run_hc(3'b001, 1000, 1'b0, 1, 1'b0, '0);
        expect_st(1'b0, 3'b000, "R1 equal level not low");
        for (int i = 0; i < 2; i++) begin
            run_hc(3'b001, 999, 1'b1, 0, 1'b0, '0);
            expect_st(1'b0, 3'b000, "R1 negative 999 counting");
        end
        run_hc(3'b001, 999, 1'b1, 0, 1'b0, '0);
        expect_st(1'b1, 3'b001, "R1 negative 999 is low");
        wr_status(CLR);
        expect_st(1'b0, 3'b000, "R6 clear again");

        // R3: phase B, a high half cycle (peak on strobe sample) restarts count
        run_hc(3'b010, 500, 1'b0, 1, 1'b0, '0);
        run_hc(3'b010, 500, 1'b0, 1, 1'b0, '0);
        run_hc(3'b010, 2000, 1'b1, 3, 1'b0, '0);
        expect_st(1'b0, 3'b000, "R3 high half cycle on strobe sample");
        run_hc(3'b010, 500, 1'b0, 1, 1'b0, '0);
        run_hc(3'b010, 500, 1'b0, 1, 1'b0, '0);
        expect_st(1'b0, 3'b000, "R3 count restarted");
        run_hc(3'b010, 500, 1'b0, 1, 1'b0, '0);
        expect_st(1'b1, 3'b010, "R3 third low after restart sets B");
        wr_status(CLR);
        expect_st(1'b0, 3'b000, "R6 clear B");

        // R11 / R5: rearm all, A and C together, then B accumulates
        run_hc(3'b111, 5000, 1'b0, 2, 1'b0, '0);
        expect_st(1'b0, 3'b000, "R11 rearm all");
        for (int i = 0; i < 3; i++) run_hc(3'b101, 300, 1'b0, 1, 1'b0, '0);
        expect_st(1'b1, 3'b101, "R11 A and C together");
        for (int i = 0; i < 3; i++) run_hc(3'b010, 300, 1'b1, 1, 1'b0, '0);
        expect_st(1'b1, 3'b111, "R5 B accumulates");
        wr_status(CLR);
        expect_st(1'b0, 3'b000, "R6 clear all three");

        // R4: count 0 acts as 1
        run_hc(3'b111, 5000, 1'b0, 2, 1'b0, '0);
        sag_cycles = 8'd0;
        run_hc(3'b001, 300, 1'b0, 1, 1'b0, '0);
        expect_st(1'b1, 3'b001, "R4 zero count fires on one low");

        // R8: new B event in the same cycle as a clear
        run_hc(3'b010, 300, 1'b0, 1, 1'b1, CLR);
        expect_st(1'b1, 3'b010, "R8 new event wins over clear");
        wr_status(CLR);
        expect_st(1'b0, 3'b000, "R7 irq released after clear");

        wait (sb_q.size() == 0);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule